// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block produces the internal chip reset and the CPU run enable. Two sources can force a reset: an external reset pin, which is first synchronised and then glitch-filtered, and a one-cycle reset request from the watchdog. Once every source has gone quiet, the sequencer waits for the oscillator-good indication. It then counts a fixed number of clocks while the oscillator stays good, and finally waits for the flash controller to report that its initialisation is done. Only after all of that does it drop the internal reset and let the CPU fetch from the reset vector.

The same oscillator wait and clock count also serve a wake-up from power-down. A wake event that arrives while the CPU is running stops the CPU and sends the sequencer back through the oscillator check and the count. On this path the internal reset stays low and the flash wait is skipped.

A one-hot status vector shows the current phase. The address the CPU fetches from after release is given as an output.

Top module: `rst_wake_ctrl`

## Requirements
- R1: While `rst` is high, the sequencer is held in the reset phase: `state_oh` = 5'b00001, `sys_rst` = 1 and `cpu_run` = 0.
- R2: `rst_pin` passes through a two-flop synchroniser and then a filter. The filter accepts a new level only after it has been sampled on 4 consecutive rising edges. An assertion first sampled at edge k and held for at least 4 edges puts the sequencer in the reset phase after edge k+6. A pulse shorter than 4 samples changes no output.
- R3: A `wdog_req` high at a rising edge, in any phase, puts the sequencer in the reset phase with `sys_rst` = 1 after that edge.
- R4: The reset phase is held for as long as the filtered pin is asserted. The edge after the filtered pin is released with no watchdog request, the sequencer moves to the oscillator-wait phase.
- R5: In the oscillator-wait phase the sequencer stays put while `osc_ok` is low. It enters the count phase at the first edge where `osc_ok` is high.
- R6: The count phase lasts exactly WAKE_CYC clock cycles, provided `osc_ok` stays high throughout. If `osc_ok` is low at any edge during the count, the sequencer returns to the oscillator-wait phase and the count starts again from zero.
- R7: On the reset path, the end of the count leads to the flash-wait phase. That phase is held until `flash_done` is high at an edge, and the sequencer then enters the run phase.
- R8: `cpu_run` is 1 only in the run phase. On the reset path, `sys_rst` is 1 in every phase except run.
- R9: A `pd_wake` pulse during the run phase takes the sequencer to the oscillator-wait phase with `sys_rst` = 0 and `cpu_run` = 0. After the count it goes straight to run, whatever `flash_done` is. `pd_wake` has no effect in any other phase, and a reset source takes priority over it.
- R10: `state_oh` is one-hot: bit 0 is reset, bit 1 oscillator wait, bit 2 count, bit 3 flash wait, bit 4 run.
- R11: `boot_pc` always equals the parameter RESET_VECTOR, which defaults to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer itself |
| rst_pin | input | 1 | Raw external reset, 1 = asserted, asynchronous |
| wdog_req | input | 1 | Watchdog reset request, one cycle |
| osc_ok | input | 1 | Oscillator is running with enough amplitude |
| flash_done | input | 1 | Flash controller initialisation complete |
| pd_wake | input | 1 | Wake event from power-down |
| sys_rst | output | 1 | Internal chip reset |
| cpu_run | output | 1 | CPU may execute |
| state_oh | output | 5 | One-hot phase status |
| boot_pc | output | ADDR_W | Reset vector fetched after release |

## Verification
The bench sends pin pulses of three and four samples, which land on either side of the filter threshold. A filter with an off-by-one count would either reset the chip on a three-sample glitch or miss a genuine four-sample reset. It drops `osc_ok` partway through the count, so a timer that does not restart ends the wait early, and it sends a wake with `flash_done` low, so a sequencer that does not skip the flash wait hangs there. It also fires watchdog requests both in run and in mid-count, so a design that gives a wake or a count priority over a reset is caught.

// File: rtl/rwk_pkg.sv
package rwk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_RESET = 3'd0,
        ST_WAIT_OSC   = 3'd1,
        ST_COUNT      = 3'd2,
        ST_WAIT_FLASH = 3'd3,
        ST_RUN        = 3'd4
    } rwk_state_e;

    localparam int RWK_NSTATE = 5;

    typedef struct packed {
        logic sys_rst;
        logic cpu_run;
    } rwk_ctl_t;

    typedef struct packed {
        logic clr;
        logic en;
    } rwk_tmr_cmd_t;

    function automatic logic [RWK_NSTATE-1:0] rwk_status(input rwk_state_e s);
        logic [RWK_NSTATE-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    function automatic rwk_ctl_t rwk_decode(input rwk_state_e s, input logic wake_mode);
        rwk_ctl_t c;
        c.cpu_run = (s == ST_RUN);
        c.sys_rst = (s != ST_RUN) && !wake_mode;
        return c;
    endfunction

endpackage

// File: rtl/rwk_pin_filter.sv
module rwk_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    output logic pin_filt
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_cnt;
    logic                   filt_q;
    logic                   samp;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b0;
                else     sync_q[0] <= pin_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b0;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign samp = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            filt_q  <= 1'b0;
        end else if (samp == filt_q) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_W'(FILT_LEN - 1)) begin
            run_cnt <= '0;
            filt_q  <= samp;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign pin_filt = filt_q;
endmodule

// File: rtl/rwk_wake_timer.sv
module rwk_wake_timer
    import rwk_pkg::*;
#(
    parameter int WAKE_CYC = 4096
) (
    input  logic         clk,
    input  logic         rst,
    input  rwk_tmr_cmd_t cmd,
    output logic         done
);
    localparam int CNT_W = $clog2(WAKE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cmd.clr) cnt_q <= '0;
        else if (cmd.en)    cnt_q <= cnt_q + 1'b1;
    end

    assign done = cmd.en && (cnt_q == CNT_W'(WAKE_CYC - 1));
endmodule

// File: rtl/rwk_seq.sv
module rwk_seq
    import rwk_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         pin_filt,
    input  logic         wdog_req,
    input  logic         osc_ok,
    input  logic         flash_done,
    input  logic         pd_wake,
    input  logic         timer_done,
    output rwk_state_e   state,
    output logic         wake_mode,
    output rwk_tmr_cmd_t tmr_cmd
);
    rwk_state_e state_q, state_d;
    logic       wake_q, wake_d;

    always_comb begin
        state_d = state_q;
        wake_d  = wake_q;
        if (pin_filt || wdog_req) begin
            state_d = ST_IDLE_RESET;
            wake_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE_RESET: state_d = ST_WAIT_OSC;
                ST_WAIT_OSC:   if (osc_ok) state_d = ST_COUNT;
                ST_COUNT: begin
                    if (!osc_ok)         state_d = ST_WAIT_OSC;
                    else if (timer_done) state_d = wake_q ? ST_RUN : ST_WAIT_FLASH;
                end
                ST_WAIT_FLASH: if (flash_done) state_d = ST_RUN;
                ST_RUN: begin
                    if (pd_wake) begin
                        state_d = ST_WAIT_OSC;
                        wake_d  = 1'b1;
                    end
                end
                default: state_d = ST_IDLE_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE_RESET;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end

    always_comb begin
        tmr_cmd.clr = (state_q != ST_COUNT);
        tmr_cmd.en  = (state_q == ST_COUNT) && osc_ok;
    end

    assign state     = state_q;
    assign wake_mode = wake_q;
endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl
    import rwk_pkg::*;
#(
    parameter int          SYNC_STAGES  = 2,
    parameter int          FILT_LEN     = 4,
    parameter int          WAKE_CYC     = 4096,
    parameter int          ADDR_W       = 32,
    parameter logic [31:0] RESET_VECTOR = 32'h0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rst_pin,
    input  logic                  wdog_req,
    input  logic                  osc_ok,
    input  logic                  flash_done,
    input  logic                  pd_wake,
    output logic                  sys_rst,
    output logic                  cpu_run,
    output logic [RWK_NSTATE-1:0] state_oh,
    output logic [ADDR_W-1:0]     boot_pc
);
    logic         pin_filt;
    logic         timer_done;
    logic         wake_mode;
    rwk_state_e   state;
    rwk_tmr_cmd_t tmr_cmd;
    rwk_ctl_t     ctl;

    rwk_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst(rst), .pin_raw(rst_pin), .pin_filt(pin_filt)
    );

    rwk_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_tmr (
        .clk(clk), .rst(rst), .cmd(tmr_cmd), .done(timer_done)
    );

    rwk_seq u_seq (
        .clk(clk), .rst(rst), .pin_filt(pin_filt), .wdog_req(wdog_req),
        .osc_ok(osc_ok), .flash_done(flash_done), .pd_wake(pd_wake),
        .timer_done(timer_done), .state(state), .wake_mode(wake_mode),
        .tmr_cmd(tmr_cmd)
    );

    assign ctl      = rwk_decode(state, wake_mode);
    assign sys_rst  = ctl.sys_rst;
    assign cpu_run  = ctl.cpu_run;
    assign state_oh = rwk_status(state);
    assign boot_pc  = RESET_VECTOR[ADDR_W-1:0];
endmodule

// File: rtl/rwk_chk.sv
module rwk_chk (
    input logic       clk,
    input logic       rst,
    input logic       pin_filt,
    input logic       wdog_req,
    input logic       osc_ok,
    input logic       flash_done,
    input logic       pd_wake,
    input logic       sys_rst,
    input logic       cpu_run,
    input logic [4:0] state_oh
);
    // R10
    state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);

    // R3
    wdog_reset_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_req |=> state_oh[0] && sys_rst);

    // R4
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pin_filt |=> state_oh[0]);

    // R5
    osc_wait_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[1] && !osc_ok |=> !state_oh[2]);

    // R6
    osc_drop_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[2] && !osc_ok && !wdog_req && !pin_filt |=> state_oh[1]);

    // R7
    flash_gate_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[3] && !flash_done |=> !cpu_run);

    // R8
    run_excl_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_run |-> !sys_rst && state_oh[4]);

    // R9
    wake_path_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[4] && pd_wake && !wdog_req && !pin_filt |=> state_oh[1] && !sys_rst && !cpu_run);
endmodule

bind rst_wake_ctrl rwk_chk u_chk (
    .clk(clk), .rst(rst), .pin_filt(pin_filt), .wdog_req(wdog_req),
    .osc_ok(osc_ok), .flash_done(flash_done), .pd_wake(pd_wake),
    .sys_rst(sys_rst), .cpu_run(cpu_run), .state_oh(state_oh)
);

// File: tb/sim_rst_wake_ctrl.sv
`timescale 1ns/1ps
module sim_rst_wake_ctrl;
    localparam int W = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pin = 1'b0, wdog_req = 1'b0, osc_ok = 1'b0, flash_done = 1'b0, pd_wake = 1'b0;
    logic sys_rst, cpu_run;
    logic [4:0] state_oh;
    logic [31:0] boot_pc;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit started = 0;

    always #2 clk = ~clk;

    rst_wake_ctrl #(.WAKE_CYC(W)) u0 (
        .clk(clk), .rst(rst), .rst_pin(rst_pin), .wdog_req(wdog_req),
        .osc_ok(osc_ok), .flash_done(flash_done), .pd_wake(pd_wake),
        .sys_rst(sys_rst), .cpu_run(cpu_run), .state_oh(state_oh), .boot_pc(boot_pc)
    );

    // behavioural reference: 0 reset, 1 osc wait, 2 count, 3 flash wait, 4 run
    int mstate = 0, mcnt = 0;
    bit mwake = 0, mfilt = 0;
    bit hist[$];

    always @(posedge clk) begin
        if (rst) begin
            mstate = 0; mcnt = 0; mwake = 0; mfilt = 0;
            hist = '{0, 0, 0, 0, 0, 0};
        end else begin
            bit old_filt;
            old_filt = mfilt;
            if (hist[$-1] != old_filt && hist[$-2] != old_filt &&
                hist[$-3] != old_filt && hist[$-4] != old_filt)
                mfilt = !old_filt;
            hist.push_back(rst_pin);
            if (hist.size() > 8) void'(hist.pop_front());
            if (old_filt || wdog_req) begin
                mstate = 0; mwake = 0;
            end else begin
                case (mstate)
                    0: mstate = 1;
                    1: if (osc_ok) begin mstate = 2; mcnt = 0; end
                    2: begin
                        if (!osc_ok) mstate = 1;
                        else if (mcnt == W - 1) mstate = mwake ? 4 : 3;
                        else mcnt++;
                    end
                    3: if (flash_done) mstate = 4;
                    default: if (pd_wake) begin mstate = 1; mwake = 1; end
                endcase
            end
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(cur_req, "state_oh", state_oh, 5'b1 << mstate);
            check(cur_req, "sys_rst", sys_rst, (mstate != 4) && !mwake);
            check(cur_req, "cpu_run", cpu_run, mstate == 4);
            check("R11", "boot_pc", boot_pc, 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int t0;
        @(posedge clk); started = 1;
        cyc(3);
        check("R1", "state_oh in reset", state_oh, 5'b00001);
        check("R1", "sys_rst in reset", sys_rst, 1);
        rst = 0;
        cur_req = "R5"; cyc(10);
        check("R5", "osc wait", state_oh, 5'b00010);
        osc_ok = 1;
        cur_req = "R6"; cyc(8);
        osc_ok = 0; cyc(1); osc_ok = 1;
        t0 = 0;
        cyc(1);
        while (state_oh[2]) begin t0++; cyc(1); end
        check("R6", "count length after restart", t0, W);
        cur_req = "R7"; cyc(10);
        check("R7", "flash wait hold", state_oh, 5'b01000);
        flash_done = 1; cyc(3);
        check("R7", "run after flash", cpu_run, 1);
        cur_req = "R2";
        rst_pin = 1; cyc(3); rst_pin = 0; cyc(12);
        check("R2", "3-sample glitch ignored", cpu_run, 1);
        rst_pin = 1; cyc(4); rst_pin = 0; cyc(4);
        check("R2", "4-sample pulse resets", sys_rst, 1);
        cur_req = "R4";
        rst_pin = 1; cyc(15);
        check("R4", "held in reset", state_oh, 5'b00001);
        rst_pin = 0; cyc(W + 20);
        check("R8", "run reached", cpu_run, 1);
        cur_req = "R9";
        flash_done = 0;
        pd_wake = 1; cyc(1); pd_wake = 0; cyc(2);
        check("R9", "wake keeps sys_rst low", sys_rst, 0);
        check("R9", "wake stops cpu", cpu_run, 0);
        pd_wake = 1; cyc(1); pd_wake = 0;
        cyc(W + 4);
        check("R9", "wake skips flash wait", cpu_run, 1);
        cur_req = "R3";
        wdog_req = 1; pd_wake = 1; cyc(1); wdog_req = 0; pd_wake = 0;
        check("R3", "watchdog in run", state_oh, 5'b00001);
        flash_done = 1; cyc(8);
        wdog_req = 1; cyc(1); wdog_req = 0;
        check("R3", "watchdog in count", sys_rst, 1);
        cur_req = "R8"; cyc(W + 10);
        check("R8", "final run", cpu_run, 1);
        started = 0;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule